// File: doc/BRIEF.md
# Seeded Scan-Gated Scramble Generator

This block is a pseudorandom generator that feeds a secure scan wrapper. It is a ring of M flip-flops. Each bit shifts one place toward bit 0, bit 0 wraps back to the top of the ring, and bit 0 is also XORed into a few fixed positions along the way. From that one ring it derives two N-bit vectors. The scramble vector is XORed onto the scan-in slice. The select vector steers the muxes that choose which internal node masks each scan-out bit.

The ring only moves during scan shifting. When scan enable is low, in functional or capture cycles, it keeps its state, so the outputs stay fixed. The seed comes from storage outside the block, which appears here as a static input port. During system reset, each flip-flop is driven to its seed bit through an asynchronous set or clear. That seed bit decides which of the two is used.

Top module: `scan_scramble_prpg`

## Requirements
- R1: While `rst_n` is low, every ring bit equals the matching `seed` bit: set when the seed bit is 1, cleared when it is 0. The outputs show the seeded state as soon as reset is applied, without waiting for a clock edge. Outside reset, changes on `seed` have no effect.
- R2: On a rising clock edge with `scan_en` low, the ring keeps its state, and both output vectors stay unchanged.
- R3: On a rising clock edge with `scan_en` high, the ring steps once:
  - new bit M-1 = old bit 0;
  - new bit i (i < M-1) = old bit i+1 XOR (old bit 0 AND `TAP_MASK[i]`);
  - the default `TAP_MASK` has bits 62, 60 and 59 set.
- R4: Bit j of `scramble_vec` is the XOR, over t from 0 to `SCR_TERMS`-1, of ring bit (`SCR_OFFSET` + j·`SCR_STRIDE` + t·`SCR_SPREAD`) mod M. The defaults are 3 terms, offset 0, stride 4 and spread 21.
- R5: Bit j of `select_vec` uses the same rule with the `SEL_*` parameters. The defaults are 1 term, offset 2 and stride 4, so bit j is taken directly from ring bit 2+4j.
- R6: An all-zero seed leaves the ring at zero, and both vectors at zero, for any amount of scan activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test/system clock |
| rst_n | input | 1 | Active-low system reset; loads the seed asynchronously |
| scan_en | input | 1 | Scan-shift qualifier; the ring steps only when high |
| seed | input | M | Per-bit reset value from external seed storage |
| scramble_vec | output | N | Scan-input scrambling slice |
| select_vec | output | N | Scan-output mask node selection slice |

## Verification
The hardest case to reach is a run of stepping that is broken by scan-enable gaps of varied length, together with seed changes that must be ignored. A reference model can only track this if it knows exactly which edges advanced the ring. The driver keeps a model ring alongside the design and steps it only on the edges where it raised `scan_en`. It uses all-high, alternating, all-low and pseudorandom enable patterns, and toggles `seed` at the start of each burst. A reset applied mid-run with a fresh seed, a single-bit seed and an all-zero seed cover the initialization and the degenerate ring.

// File: rtl/scan_prpg_pkg.sv
package scan_prpg_pkg;

  // Ring bit feeding term t of output bit j of a tap network.
  function automatic int unsigned tap_index(
    input int unsigned offset,
    input int unsigned stride,
    input int unsigned spread,
    input int unsigned j,
    input int unsigned t,
    input int unsigned m
  );
    return (offset + j * stride + t * spread) % m;
  endfunction

endpackage

// File: rtl/prpg_seed_cell.sv
module prpg_seed_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic seed_bit,
  input  logic step_en,
  input  logic d_next,
  output logic q
);

  logic set_req;
  logic clr_req;
  logic q_nxt;

  // Seed bit steers reset onto either the set or the clear pin.
  assign set_req = ~rst_n & seed_bit;
  assign clr_req = ~rst_n & ~seed_bit;

  always_comb begin
    q_nxt = step_en ? d_next : q;
  end

  always_ff @(posedge clk or posedge set_req or posedge clr_req) begin
    if (set_req) begin
      q <= 1'b1;
    end else if (clr_req) begin
      q <= 1'b0;
    end else begin
      q <= q_nxt;
    end
  end

  assert_seed_load_R1: assert property (@(posedge clk) !rst_n |-> (q == seed_bit))
    else $error("seed cell does not hold its seed bit during reset");

endmodule

// File: rtl/prpg_ring.sv
module prpg_ring #(
  parameter int unsigned M = 64,
  parameter logic [M-1:0] TAP_MASK = 64'h5800_0000_0000_0000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  input  logic [M-1:0] seed,
  output logic [M-1:0] state
);

  logic [M-1:0] state_nxt;
  logic         fb;

  assign fb = state[0];

  // Next state: rotate toward bit 0, inject feedback at tap positions.
  always_comb begin
    state_nxt[M-1] = fb;
    for (int i = 0; i < int'(M) - 1; i++) begin
      state_nxt[i] = state[i+1] ^ (fb & TAP_MASK[i]);
    end
  end

  for (genvar g = 0; g < M; g++) begin : g_cell
    prpg_seed_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .seed_bit (seed[g]),
      .step_en  (step_en),
      .d_next   (state_nxt[g]),
      .q        (state[g])
    );
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(state))
    else $error("ring moved while scan enable was low");

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> (state[M-1] == $past(state[0])))
    else $error("ring top bit did not receive the old bottom bit");

  assert_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != '0) |=> (state != '0))
    else $error("nonzero ring collapsed to zero");

endmodule

// File: rtl/prpg_tap_net.sv
module prpg_tap_net #(
  parameter int unsigned M      = 64,
  parameter int unsigned N      = 16,
  parameter int unsigned TERMS  = 1,
  parameter int unsigned OFFSET = 0,
  parameter int unsigned STRIDE = 4,
  parameter int unsigned SPREAD = 21
) (
  input  logic [M-1:0] state,
  output logic [N-1:0] vec
);

  import scan_prpg_pkg::*;

  for (genvar j = 0; j < N; j++) begin : g_bit
    if (TERMS == 1) begin : g_direct
      localparam int unsigned IDX = tap_index(OFFSET, STRIDE, SPREAD, j, 0, M);
      assign vec[j] = state[IDX];
    end else begin : g_xor
      logic [TERMS-1:0] term;
      for (genvar t = 0; t < TERMS; t++) begin : g_term
        localparam int unsigned IDX = tap_index(OFFSET, STRIDE, SPREAD, j, t, M);
        assign term[t] = state[IDX];
      end
      assign vec[j] = ^term;
    end
  end

endmodule

// File: rtl/scan_scramble_prpg.sv
module scan_scramble_prpg #(
  parameter int unsigned M          = 64,
  parameter int unsigned N          = 16,
  parameter logic [M-1:0] TAP_MASK  = 64'h5800_0000_0000_0000,
  parameter int unsigned SCR_TERMS  = 3,
  parameter int unsigned SCR_OFFSET = 0,
  parameter int unsigned SCR_STRIDE = 4,
  parameter int unsigned SCR_SPREAD = 21,
  parameter int unsigned SEL_TERMS  = 1,
  parameter int unsigned SEL_OFFSET = 2,
  parameter int unsigned SEL_STRIDE = 4,
  parameter int unsigned SEL_SPREAD = 21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scan_en,
  input  logic [M-1:0] seed,
  output logic [N-1:0] scramble_vec,
  output logic [N-1:0] select_vec
);

  logic [M-1:0] ring_q;

  prpg_ring #(
    .M        (M),
    .TAP_MASK (TAP_MASK)
  ) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (scan_en),
    .seed    (seed),
    .state   (ring_q)
  );

  prpg_tap_net #(
    .M      (M),
    .N      (N),
    .TERMS  (SCR_TERMS),
    .OFFSET (SCR_OFFSET),
    .STRIDE (SCR_STRIDE),
    .SPREAD (SCR_SPREAD)
  ) u_scr_net (
    .state (ring_q),
    .vec   (scramble_vec)
  );

  prpg_tap_net #(
    .M      (M),
    .N      (N),
    .TERMS  (SEL_TERMS),
    .OFFSET (SEL_OFFSET),
    .STRIDE (SEL_STRIDE),
    .SPREAD (SEL_SPREAD)
  ) u_sel_net (
    .state (ring_q),
    .vec   (select_vec)
  );

  assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> ($stable(scramble_vec) && $stable(select_vec)))
    else $error("output vectors changed outside scan shifting");

endmodule

// File: tb/scan_scramble_prpg_test.sv
module scan_scramble_prpg_test;

  localparam int M = 64;
  localparam int N = 16;
  localparam logic [M-1:0] MASK = 64'h5800_0000_0000_0000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         scan_en;
  logic [M-1:0] seed;
  logic [N-1:0] scramble_vec;
  logic [N-1:0] select_vec;

  always #5 clk = ~clk;

  scan_scramble_prpg #(
    .M(M), .N(N), .TAP_MASK(MASK),
    .SCR_TERMS(3), .SCR_OFFSET(0), .SCR_STRIDE(4), .SCR_SPREAD(21),
    .SEL_TERMS(1), .SEL_OFFSET(2), .SEL_STRIDE(4), .SEL_SPREAD(21)
  ) uut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .seed(seed),
    .scramble_vec(scramble_vec), .select_vec(select_vec)
  );

  typedef struct {
    logic [N-1:0] k;
    logic [N-1:0] s;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  int           checks = 0;
  int           errors = 0;
  logic [M-1:0] ms;
  logic [31:0]  lcg = 32'h1234_5678;

  function automatic logic [M-1:0] ref_step(input logic [M-1:0] s);
    logic [M-1:0] r;
    r = {s[0], s[M-1:1]};
    if (s[0]) r = r ^ MASK;
    return r;
  endfunction

  function automatic logic [N-1:0] ref_vec(input logic [M-1:0] s, input int off,
                                           input int stride, input int spread, input int terms);
    logic [N-1:0] v;
    for (int j = 0; j < N; j++) begin
      v[j] = 1'b0;
      for (int t = 0; t < terms; t++) v[j] = v[j] ^ s[(off + j*stride + t*spread) % M];
    end
    return v;
  endfunction

  function automatic logic [N-1:0] exp_k(input logic [M-1:0] s);
    return ref_vec(s, 0, 4, 21, 3);
  endfunction

  function automatic logic [N-1:0] exp_s(input logic [M-1:0] s);
    return ref_vec(s, 2, 4, 21, 1);
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: chooses scan_en for the next edge, advances the model, queues the result.
  // mode 0 all high, 1 alternating, 2 all low, 3 pseudorandom.
  task automatic drive(input int n, input int mode, input string tag);
    logic en;
    @(negedge clk);
    seed = ~seed;  // seed toggled outside reset must be ignored (R1)
    for (int i = 0; i < n; i++) begin
      if (i != 0) @(negedge clk);
      case (mode)
        0: en = 1'b1;
        1: en = i[0];
        2: en = 1'b0;
        default: begin
          lcg = lcg * 32'd1664525 + 32'd1013904223;
          en  = lcg[20];
        end
      endcase
      scan_en = en;
      if (en) ms = ref_step(ms);
      sb.push_back('{k: exp_k(ms), s: exp_s(ms), tag: (en ? tag : "R2")});
    end
  endtask

  task automatic do_reset(input logic [M-1:0] sd);
    @(posedge clk);
    #3;
    scan_en = 1'b0;
    seed    = sd;
    #1;
    rst_n = 1'b0;
    #1;
    ms = sd;
    check("R1 scramble immediate", scramble_vec, exp_k(sd));
    check("R1 select immediate", select_vec, exp_s(sd));
    @(negedge clk);
    check("R1 scramble held in reset", scramble_vec, exp_k(sd));
    check("R1 select held in reset", select_vec, exp_s(sd));
    rst_n = 1'b1;
  endtask

  // Monitor: pops one expected item per edge after the design settles.
  initial begin
    exp_t it;
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() != 0) begin
        it = sb.pop_front();
        check({it.tag, " R4 scramble"}, scramble_vec, it.k);
        check({it.tag, " R5 select"}, select_vec, it.s);
      end
    end
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n   = 1'b1;
    scan_en = 1'b0;
    seed    = '0;
    #1;
    do_reset(64'hA5F0_3C96_1E2D_7B48);
    drive(70, 0, "R3");
    drive(40, 1, "R3");
    drive(20, 2, "R2");
    drive(150, 3, "R3");
    do_reset({M{1'b1}});
    drive(80, 0, "R3");
    drive(60, 3, "R3");
    do_reset(64'h0000_0000_0000_0001);
    drive(100, 0, "R3");
    do_reset('0);
    seed = '0;
    drive(30, 0, "R6");
    @(posedge clk);
    #3;
    check("R6 scramble stays zero", scramble_vec, '0);
    check("R6 select stays zero", select_vec, '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule